// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block produces the internal timing and the sleep control for a small 8-bit controller core. The external oscillator clock first passes through a divide-by-two stage. The halved clock then drives a machine-cycle sequencer that emits a one-clock strobe every twelve oscillator periods.

The reset pin works at two speeds. The port-force-high output follows the pin at once, with no clock involved. The core reset, by contrast, goes active only after the synchronized pin has stayed high for two complete machine cycles while the oscillator runs.

Software can park the core in one of two sleep modes:
- **Idle** stops only the CPU clock enable. It ends on a pending enabled interrupt or on a qualified reset.
- **Power-down** drops the oscillator-run enable and freezes all timing. Only the reset pin can end it, and reset qualification restarts once the oscillator is enabled again.

The block never issues any write or clear toward the on-chip RAM, so RAM contents survive every reset.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: While `osc_run_en` is 1, `phi_clk` changes value on every rising edge of `osc_clk` (half the oscillator rate).
- R2: While the oscillator runs, `mc_stb` is a single-cycle pulse that recurs exactly every 12 `osc_clk` cycles.
- R3: Whenever `rst_pin` is 1, `port_hi` is 1, with no clock edge needed.
- R4: `core_rst_n` (active low) goes to 0 no earlier than 24 and no later than 40 `osc_clk` cycles after `rst_pin` rises. A pin pulse shorter than 24 cycles never asserts it. After the pin falls, `core_rst_n` returns to 1 within 4 cycles.
- R5: A one-cycle `idle_req` in run mode clears `cpu_clk_en` from the next cycle. `per_clk_en` and `osc_run_en` stay at 1.
- R6: In idle, a 1 on `irq_pend` sets `cpu_clk_en` again in the next cycle.
- R7: A one-cycle `pd_req` clears `osc_run_en`, `cpu_clk_en` and `per_clk_en` from the next cycle. After that, `phi_clk` holds still and `mc_stb` stays 0.
- R8: Power-down ignores `irq_pend`. Only `rst_pin` ends it: `osc_run_en` returns to 1 within 3 cycles of the pin rising, and the core reset follows at least 24 cycles after that.
- R9: When `idle_req` and `pd_req` arrive in the same cycle, power-down is entered.
- R10: While `core_rst_n` is 0, mode requests have no effect and `cpu_clk_en` stays at 1.
- R11: A qualified reset taken during idle turns `cpu_clk_en` back to 1 while `core_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | External oscillator clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| idle_req | input | 1 | Software request to enter idle, one-cycle pulse |
| pd_req | input | 1 | Software request to enter power-down, one-cycle pulse |
| irq_pend | input | 1 | An enabled interrupt is pending |
| phi_clk | output | 1 | Divided-by-two phase clock |
| mc_stb | output | 1 | Machine-cycle strobe, one cycle in twelve |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator-run enable |
| core_rst_n | output | 1 | Core reset, active low |
| port_hi | output | 1 | Forces all I/O pins high |

## Verification
The hardest case to reach is the way out of power-down. The oscillator-run enable is off, so the qualification counter can only begin after the synchronized pin has restarted the sequencer. This means the reset latency stacks two delays.

The bench first parks the block in power-down. It then shows that interrupts do nothing there. Finally it raises the pin and measures two things separately: the delay until the oscillator is re-enabled, and the further delay until the core reset appears.

A pin pulse shorter than two machine cycles is also driven, to show that the core reset stays quiet while the ports are still forced high.

// File: rtl/clk_pwr_pkg.sv
// Package: shared types and defaults for the clock, reset and power-mode controller.
// Assumes: a single oscillator clock domain.
package clk_pwr_pkg;

    // Operating modes of the controller
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_state_e;

    // Phase-clock periods per machine cycle (12 oscillator periods)
    localparam int unsigned PHASES_PER_MC_DEF = 6;
    // Full machine cycles the reset pin must hold before core reset
    localparam int unsigned QUAL_MC_DEF       = 2;
    // Synchronizer depth for the reset pin
    localparam int unsigned SYNC_STAGES_DEF   = 2;

endpackage

// File: rtl/cpc_pin_sync.sv
// Module: cpc_pin_sync
// Carries an asynchronous level into the oscillator domain through a
// flop chain of STAGES depth. No reset: the chain flushes itself by
// shifting while the clock runs.
module cpc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic osc_clk,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level along the chain
    always_ff @(posedge osc_clk) begin
        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cpc_phase_gen.sv
// Module: cpc_phase_gen
// Halves the oscillator clock, then counts phase periods to mark each
// machine cycle with a one-clock strobe. Everything freezes while
// run_en is low. The phase counter wraps from any value, so it needs
// no reset.
module cpc_phase_gen #(
    parameter int unsigned PHASES_PER_MC = 6
) (
    input  logic osc_clk,
    input  logic run_en,
    output logic phi,
    output logic stb
);

    localparam int unsigned PW = (PHASES_PER_MC > 1) ? $clog2(PHASES_PER_MC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PHASES_PER_MC - 1);

    logic          half;
    logic [PW-1:0] pcnt;

    // Divide by two and advance the phase count once per phase period
    always_ff @(posedge osc_clk) begin
        if (run_en) begin
            half <= ~half;
            if (half) begin
                pcnt <= (pcnt >= LAST) ? '0 : pcnt + 1'b1;
            end
        end
    end

    assign phi = half;
    assign stb = run_en && half && (pcnt == LAST);

endmodule

// File: rtl/cpc_rst_qual.sv
// Module: cpc_rst_qual
// Counts machine-cycle strobes while the synchronized pin is high and the
// oscillator runs. Core reset goes active once QUAL_MC+1 strobes have
// been seen, which guarantees QUAL_MC complete machine cycles. The count
// clears as soon as the synchronized pin drops.
module cpc_rst_qual #(
    parameter int unsigned QUAL_MC = 2
) (
    input  logic osc_clk,
    input  logic rst_s,
    input  logic run_en,
    input  logic stb,
    output logic core_rst_n
);

    localparam int unsigned CW = $clog2(QUAL_MC + 2);
    localparam logic [CW-1:0] TARGET = CW'(QUAL_MC + 1);

    logic [CW-1:0] qcnt;

    // Count strobes while the pin is held, saturating at the target
    always_ff @(posedge osc_clk) begin
        if (!rst_s) begin
            qcnt <= '0;
        end else if (run_en && stb && (qcnt != TARGET)) begin
            qcnt <= qcnt + 1'b1;
        end
    end

    assign core_rst_n = (qcnt != TARGET);

endmodule

// File: rtl/cpc_mode_fsm.sv
// Module: cpc_mode_fsm
// Run / idle / power-down sequencer. The active-low core reset returns it
// to run synchronously. Power-down has priority over idle. Power-down
// leaves only on the synchronized pin, because core reset cannot qualify
// while the oscillator is stopped.
module cpc_mode_fsm
    import clk_pwr_pkg::*;
(
    input  logic      osc_clk,
    input  logic      core_rst_n,
    input  logic      rst_s,
    input  logic      idle_req,
    input  logic      pd_req,
    input  logic      irq_pend,
    output pm_state_e mode
);

    pm_state_e nxt;

    // Choose the next mode from the requests
    always_comb begin
        nxt = mode;
        unique case (mode)
            PM_RUN: begin
                if (pd_req)        nxt = PM_PDOWN;
                else if (idle_req) nxt = PM_IDLE;
            end
            PM_IDLE:  if (irq_pend) nxt = PM_RUN;
            PM_PDOWN: if (rst_s)    nxt = PM_RUN;
            default:  nxt = PM_RUN;
        endcase
    end

    // Register the mode, with synchronous active-low reset
    always_ff @(posedge osc_clk) begin
        if (!core_rst_n) mode <= PM_RUN;
        else             mode <= nxt;
    end

endmodule

// File: rtl/clk_pwr_ctrl.sv
// Module: clk_pwr_ctrl (top)
// Clock, reset and power-mode controller for a small 8-bit core.
// Assumes: osc_clk keeps toggling at the pin even while osc_run_en is low;
// the oscillator itself lies outside this block. Only port_hi responds
// to rst_pin without a clock.
module clk_pwr_ctrl
    import clk_pwr_pkg::*;
#(
    parameter int unsigned PHASES_PER_MC = PHASES_PER_MC_DEF,
    parameter int unsigned QUAL_MC       = QUAL_MC_DEF,
    parameter int unsigned SYNC_STAGES   = SYNC_STAGES_DEF
) (
    input  logic osc_clk,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    output logic phi_clk,
    output logic mc_stb,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_run_en,
    output logic core_rst_n,
    output logic port_hi
);

    logic      rst_s;
    pm_state_e mode;

    cpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .osc_clk (osc_clk),
        .d_async (rst_pin),
        .q_sync  (rst_s)
    );

    cpc_phase_gen #(.PHASES_PER_MC(PHASES_PER_MC)) u_phase (
        .osc_clk (osc_clk),
        .run_en  (osc_run_en),
        .phi     (phi_clk),
        .stb     (mc_stb)
    );

    cpc_rst_qual #(.QUAL_MC(QUAL_MC)) u_qual (
        .osc_clk    (osc_clk),
        .rst_s      (rst_s),
        .run_en     (osc_run_en),
        .stb        (mc_stb),
        .core_rst_n (core_rst_n)
    );

    cpc_mode_fsm u_fsm (
        .osc_clk    (osc_clk),
        .core_rst_n (core_rst_n),
        .rst_s      (rst_s),
        .idle_req   (idle_req),
        .pd_req     (pd_req),
        .irq_pend   (irq_pend),
        .mode       (mode)
    );

    // Decode the enables from the mode; force ports high from the pin directly
    assign cpu_clk_en = (mode == PM_RUN);
    assign per_clk_en = (mode != PM_PDOWN);
    assign osc_run_en = (mode != PM_PDOWN);
    assign port_hi    = rst_pin | ~core_rst_n;

endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
// Module: clk_pwr_ctrl_chk
// Property checker attached to clk_pwr_ctrl. It watches only ports.
module clk_pwr_ctrl_chk (
    input logic osc_clk,
    input logic rst_pin,
    input logic pd_req,
    input logic mc_stb,
    input logic phi_clk,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_run_en,
    input logic core_rst_n
);

    // Ports are forced high whenever the pin is high
    always_ff @(posedge osc_clk) begin
        AST_PIN_FORCES_PORTS: assert (!rst_pin || clk_pwr_ctrl.port_hi); // R3
    end

    AST_STB_SINGLE: assert property (@(posedge osc_clk) disable iff (!core_rst_n)
        mc_stb |=> !mc_stb); // R2

    AST_PHI_TOGGLES: assert property (@(posedge osc_clk) disable iff (!core_rst_n)
        (osc_run_en && $past(osc_run_en)) |-> (phi_clk != $past(phi_clk))); // R1

    AST_PD_SILENT: assert property (@(posedge osc_clk) disable iff (!core_rst_n)
        !osc_run_en |-> (!mc_stb && !cpu_clk_en && !per_clk_en)); // R7

    AST_IDLE_PER_ON: assert property (@(posedge osc_clk) disable iff (!core_rst_n)
        (osc_run_en && !cpu_clk_en) |-> per_clk_en); // R5

    AST_PD_ENTRY: assert property (@(posedge osc_clk) disable iff (!core_rst_n)
        (pd_req && cpu_clk_en) |=> !osc_run_en); // R9

    AST_RST_CPU_RUN: assert property (@(posedge osc_clk) disable iff (rst_pin)
        !core_rst_n |-> cpu_clk_en); // R10

    AST_RST_NEEDS_PIN: assert property (@(posedge osc_clk) disable iff (!osc_run_en)
        $fell(core_rst_n) |-> $past(rst_pin)); // R4

endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk u_chk (
    .osc_clk    (osc_clk),
    .rst_pin    (rst_pin),
    .pd_req     (pd_req),
    .mc_stb     (mc_stb),
    .phi_clk    (phi_clk),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_run_en (osc_run_en),
    .core_rst_n (core_rst_n)
);

// File: tb/clk_pwr_ctrl_tb.sv
// Bench: directed scenarios, one task each, each checking its own results.
`timescale 1ns/1ps
module clk_pwr_ctrl_tb;

    logic osc_clk  = 1'b0;
    logic rst_pin  = 1'b1;
    logic idle_req = 1'b0;
    logic pd_req   = 1'b0;
    logic irq_pend = 1'b0;
    logic phi_clk, mc_stb, cpu_clk_en, per_clk_en, osc_run_en, core_rst_n, port_hi;

    int n_run  = 0;
    int n_fail = 0;

    always #10 osc_clk = ~osc_clk; // 50 MHz

    clk_pwr_ctrl u_dut (
        .osc_clk    (osc_clk),
        .rst_pin    (rst_pin),
        .idle_req   (idle_req),
        .pd_req     (pd_req),
        .irq_pend   (irq_pend),
        .phi_clk    (phi_clk),
        .mc_stb     (mc_stb),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_run_en (osc_run_en),
        .core_rst_n (core_rst_n),
        .port_hi    (port_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge osc_clk);
    endtask

    // Raise the pin, return cycles until core reset is seen (cap 60)
    task automatic pin_and_measure(output int lat);
        rst_pin = 1'b1;
        lat = 0;
        while (core_rst_n !== 1'b0 && lat < 60) begin
            @(negedge osc_clk);
            lat++;
        end
    endtask

    task automatic release_pin();
        rst_pin = 1'b0;
        step(4);
        check(core_rst_n === 1'b1, "R4 release", int'(core_rst_n), 1);
    endtask

    task automatic t_init();
        int lat;
        @(negedge osc_clk);
        pin_and_measure(lat);
        check(core_rst_n === 1'b0, "R4 initial reset", int'(core_rst_n), 0);
        check(port_hi === 1'b1, "R3 ports high in reset", int'(port_hi), 1);
        release_pin();
        check(cpu_clk_en && per_clk_en && osc_run_en, "R5 run after reset",
              {cpu_clk_en, per_clk_en, osc_run_en}, 7);
    endtask

    task automatic t_clock();
        int gap;
        logic p0;
        p0 = phi_clk;
        step(1);
        check(phi_clk !== p0, "R1 phi toggles", int'(phi_clk), int'(!p0));
        while (mc_stb !== 1'b1) step(1);
        gap = 0;
        do begin step(1); gap++; end while (mc_stb !== 1'b1 && gap < 30);
        check(gap == 12, "R2 strobe period", gap, 12);
        step(1);
        check(mc_stb === 1'b0, "R2 strobe single cycle", int'(mc_stb), 0);
    endtask

    task automatic t_port_async();
        #3 rst_pin = 1'b1;
        #1 check(port_hi === 1'b1, "R3 immediate force", int'(port_hi), 1);
        rst_pin = 1'b0;
        step(1);
    endtask

    task automatic t_short_pulse();
        bit seen = 0;
        rst_pin = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (core_rst_n === 1'b0) seen = 1;
        end
        rst_pin = 1'b0;
        for (int i = 0; i < 50; i++) begin
            step(1);
            if (core_rst_n === 1'b0) seen = 1;
        end
        check(!seen, "R4 short pulse ignored", int'(seen), 0);
    endtask

    task automatic t_latency();
        int lat;
        pin_and_measure(lat);
        check(lat >= 24 && lat <= 40, "R4 qualification window", lat, 24);
        release_pin();
    endtask

    task automatic t_idle();
        idle_req = 1'b1; step(1); idle_req = 1'b0;
        check(cpu_clk_en === 1'b0, "R5 cpu off in idle", int'(cpu_clk_en), 0);
        check(per_clk_en === 1'b1 && osc_run_en === 1'b1, "R5 peripherals on",
              {per_clk_en, osc_run_en}, 3);
        step(5);
        check(cpu_clk_en === 1'b0, "R6 idle holds", int'(cpu_clk_en), 0);
        irq_pend = 1'b1; step(1); irq_pend = 1'b0;
        check(cpu_clk_en === 1'b1, "R6 irq wakes", int'(cpu_clk_en), 1);
    endtask

    task automatic t_pdown();
        logic p0;
        int strobes = 0;
        int lat;
        int lat2;
        pd_req = 1'b1; step(1); pd_req = 1'b0;
        check({osc_run_en, cpu_clk_en, per_clk_en} == 3'b000, "R7 all off",
              {osc_run_en, cpu_clk_en, per_clk_en}, 0);
        p0 = phi_clk;
        irq_pend = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (mc_stb) strobes++;
        end
        irq_pend = 1'b0;
        check(phi_clk === p0 && strobes == 0, "R7 timing frozen", strobes, 0);
        check(osc_run_en === 1'b0, "R8 irq ignored in power-down", int'(osc_run_en), 0);
        rst_pin = 1'b1;
        lat = 0;
        while (osc_run_en !== 1'b1 && lat < 10) begin step(1); lat++; end
        check(lat <= 3, "R8 oscillator restart", lat, 3);
        lat2 = 0;
        while (core_rst_n !== 1'b0 && lat2 < 60) begin step(1); lat2++; end
        check(lat2 >= 24 && lat2 <= 40, "R8 reset after restart", lat2, 24);
        release_pin();
    endtask

    task automatic t_both();
        idle_req = 1'b1; pd_req = 1'b1; step(1);
        idle_req = 1'b0; pd_req = 1'b0;
        check(osc_run_en === 1'b0, "R9 power-down wins", int'(osc_run_en), 0);
        rst_pin = 1'b1;
        while (core_rst_n !== 1'b0) step(1);
        release_pin();
    endtask

    task automatic t_req_in_reset();
        int lat;
        pin_and_measure(lat);
        idle_req = 1'b1; pd_req = 1'b1; step(1);
        idle_req = 1'b0; pd_req = 1'b0;
        step(1);
        check(cpu_clk_en === 1'b1 && osc_run_en === 1'b1, "R10 requests ignored",
              {cpu_clk_en, osc_run_en}, 3);
        release_pin();
        check(cpu_clk_en === 1'b1, "R10 still running", int'(cpu_clk_en), 1);
    endtask

    task automatic t_idle_reset();
        int lat;
        idle_req = 1'b1; step(1); idle_req = 1'b0;
        check(cpu_clk_en === 1'b0, "R11 in idle", int'(cpu_clk_en), 0);
        pin_and_measure(lat);
        step(1);
        check(core_rst_n === 1'b0 && cpu_clk_en === 1'b1, "R11 reset ends idle",
              {core_rst_n, cpu_clk_en}, 1);
        release_pin();
    endtask

    initial begin
        fork
            begin
                t_init();
                t_clock();
                t_port_async();
                t_short_pulse();
                t_latency();
                t_idle();
                t_pdown();
                t_both();
                t_req_in_reset();
                t_idle_reset();
                t_clock();
            end
            begin
                repeat (20000) @(posedge osc_clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule